// File: doc/BRIEF.md
# Capacitive Electrode Contact Monitor

This block turns the frequency of a capacitance-controlled ring oscillator into a small digital reading and decides from that reading whether a sensing electrode has come loose. The oscillator toggles at a base rate of roughly 5 MHz or 10 MHz, picked by a select input. When the electrode detaches, the sensed capacitance drops and the oscillator speeds up by around 150 kHz. The block counts oscillator rising edges over fixed gate windows timed by the system clock. With the default window of 125000 system cycles at 250 MHz, it reports one reading per window, which gives 2000 readings per second.

The oscillator drives a free-running binary counter in its own clock domain. The counter is published as a Gray code and brought into the system domain through two flops. At each window boundary the synchronised value is captured, and the edge count of the window is the difference between this capture and the one before. The baseline is subtracted from that count and the result is clamped to 0..127, giving a 7-bit reading. A hysteresis state machine watches the readings. Its flag requests a power-down or an alarm once the reading has stayed above a programmable limit for two windows in a row.

A window-control state machine has two states. WIN_PRIME gates a window whose count cannot be trusted, and WIN_MEASURE reports. After reset the block starts in WIN_PRIME, and a change on the base select forces it back there. At the end of a primed window it moves from WIN_PRIME to WIN_MEASURE. A base-select change moves it from WIN_MEASURE to WIN_PRIME.

The link state machine has four states: LINK_ATTACHED, LINK_OPEN_PENDING, LINK_DETACHED and LINK_CLOSE_PENDING. Each reported reading is graded high when it is above the threshold and low otherwise. The transitions are:
- LINK_ATTACHED goes to LINK_OPEN_PENDING on a high reading.
- LINK_OPEN_PENDING goes to LINK_DETACHED on a high reading, or back to LINK_ATTACHED on a low one.
- LINK_DETACHED goes to LINK_CLOSE_PENDING on a low reading.
- LINK_CLOSE_PENDING goes to LINK_ATTACHED on a low reading, or back to LINK_DETACHED on a high one.

The flag is high in LINK_DETACHED and in LINK_CLOSE_PENDING.

Top module: `osc_cap_monitor`

## Requirements
- R1: While reset is low, and in the cycle after it, `sample`, `sample_valid` and `disconnect` are all 0.
- R2: The reading is the number of oscillator rising edges in the window minus `baseline`, clamped to 0 when negative and to 127 when above 127.
- R3: A window lasts GATE_CYCLES system cycles. `sample_valid` is a one-cycle pulse, and consecutive pulses inside one measurement run are exactly GATE_CYCLES cycles apart.
- R4: The first window after reset is discarded. Counting the first rising edge with reset high as edge 1, the first `sample_valid` is visible after edge 2*GATE_CYCLES.
- R5: A change on `base_sel` seen at a clock edge restarts the gate, and the window that follows is discarded. No pulse appears before the next 2*GATE_CYCLES edges have passed, and the next pulse is visible right after the 2*GATE_CYCLES-th of them.
- R6: A reading is graded high only when it is strictly greater than `threshold`; a reading equal to the threshold is low. `disconnect` rises only after two consecutive high readings.
- R7: `disconnect` falls only after two consecutive low readings. A single high reading while the flag is set keeps it set and restarts the count.
- R8: `disconnect` changes only in a cycle where `sample_valid` is high. Discarded windows never advance the link state.
- R9: `sample` holds its value between `sample_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times the gate windows |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| osc_clk | input | 1 | Ring-oscillator output, asynchronous to clk |
| base_sel | input | 1 | Base-frequency select (0 slow, 1 fast); a change discards a window |
| baseline | input | CNT_W | Edge count subtracted from each window count |
| threshold | input | 7 | Reading limit above which a window is graded high |
| sample | output | 7 | Clamped reading of the last reported window |
| sample_valid | output | 1 | One-cycle strobe marking a new reading |
| disconnect | output | 1 | Electrode-detached flag with two-window hysteresis |

## Verification
The bench targets the following corner cases.
- Exact timing of the first pulse after reset and after a base-select flip. A design that reports the primed window, or that fails to restart the gate, would pulse one window early or at the wrong phase.
- Both ends of the clamp: a baseline larger than the count, and a fast oscillator with a zero baseline. Wrap-around in either case would show up as a reading near 127 or near 0.
- Directed threshold sequences: isolated high and low readings, and a reading equal to the threshold. A state machine that reacts after one window, or grades equality as high, would toggle the flag too soon.
- Random baselines, thresholds and oscillator periods. These confirm that the Gray-coded difference counting stays exact window after window.

// File: rtl/osc_cap_pkg.sv
`timescale 1ns/1ps
package osc_cap_pkg;
    localparam int READ_W = 7;

    typedef enum logic {
        WIN_PRIME,
        WIN_MEASURE
    } win_state_t;

    typedef enum logic [1:0] {
        LINK_ATTACHED,
        LINK_OPEN_PENDING,
        LINK_DETACHED,
        LINK_CLOSE_PENDING
    } link_state_t;
endpackage

// File: rtl/osc_edge_counter.sv
`timescale 1ns/1ps
// Free-running edge counter in the oscillator domain, published as Gray code.
module osc_edge_counter #(
    parameter int CNT_W = 14
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_o
);
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    assign bin_nxt = bin_q + CNT_W'(1);

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_o <= bin_nxt ^ (bin_nxt >> 1);
        end
    end
endmodule

// File: rtl/gray_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a Gray-coded bus, followed by Gray-to-binary.
module gray_sync #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_i,
    output logic [CNT_W-1:0] bin_o
);
    logic [CNT_W-1:0] meta_q;
    logic [CNT_W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_i;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        bin_o[CNT_W-1] = sync_q[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ sync_q[i];
        end
    end
endmodule

// File: rtl/link_state_fsm.sv
`timescale 1ns/1ps
// Two-window hysteresis on the graded readings.
module link_state_fsm
    import osc_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic over,
    output logic detached
);
    link_state_t state_q;
    link_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINK_ATTACHED;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        if (step) begin
            unique case (state_q)
                LINK_ATTACHED:      state_nxt = over ? LINK_OPEN_PENDING : LINK_ATTACHED;
                LINK_OPEN_PENDING:  state_nxt = over ? LINK_DETACHED     : LINK_ATTACHED;
                LINK_DETACHED:      state_nxt = over ? LINK_DETACHED     : LINK_CLOSE_PENDING;
                LINK_CLOSE_PENDING: state_nxt = over ? LINK_DETACHED     : LINK_ATTACHED;
                default:            state_nxt = LINK_ATTACHED;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            LINK_DETACHED, LINK_CLOSE_PENDING: detached = 1'b1;
            default:                           detached = 1'b0;
        endcase
    end
endmodule

// File: rtl/osc_cap_monitor.sv
`timescale 1ns/1ps
module osc_cap_monitor
    import osc_cap_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int GATE_CYCLES = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_clk,
    input  logic              base_sel,
    input  logic [CNT_W-1:0]  baseline,
    input  logic [READ_W-1:0] threshold,
    output logic [READ_W-1:0] sample,
    output logic              sample_valid,
    output logic              disconnect
);
    localparam int                GATE_W    = $clog2(GATE_CYCLES);
    localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(GATE_CYCLES - 1);
    localparam logic [CNT_W-1:0]  READ_MAX  = CNT_W'((1 << READ_W) - 1);

    logic [CNT_W-1:0]  osc_gray;
    logic [CNT_W-1:0]  cur_count;
    logic [CNT_W-1:0]  prev_snap;
    logic [CNT_W-1:0]  window_cnt;
    logic [CNT_W:0]    diff;
    logic [READ_W-1:0] reading;
    logic [GATE_W-1:0] gate_cnt;
    logic              base_q;
    logic              boundary;
    logic              restart;
    logic              report;
    logic              over;
    win_state_t        win_q;
    win_state_t        win_nxt;

    osc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .gray_o  (osc_gray)
    );

    gray_sync #(.CNT_W(CNT_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .gray_i (osc_gray),
        .bin_o  (cur_count)
    );

    assign boundary   = (gate_cnt == GATE_LAST);
    assign restart    = (base_sel != base_q);
    assign report     = boundary && !restart && (win_q == WIN_MEASURE);
    assign window_cnt = cur_count - prev_snap;
    assign diff       = {1'b0, window_cnt} - {1'b0, baseline};
    assign over       = (reading > threshold);

    always_comb begin
        if (diff[CNT_W])                   reading = '0;
        else if (diff[CNT_W-1:0] > READ_MAX) reading = '1;
        else                               reading = diff[READ_W-1:0];
    end

    // Window-control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= WIN_PRIME;
        else        win_q <= win_nxt;
    end

    always_comb begin
        unique case (win_q)
            WIN_PRIME:   win_nxt = (boundary && !restart) ? WIN_MEASURE : WIN_PRIME;
            WIN_MEASURE: win_nxt = restart ? WIN_PRIME : WIN_MEASURE;
            default:     win_nxt = WIN_PRIME;
        endcase
    end

    // Gate timing, snapshots and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_cnt     <= '0;
            base_q       <= 1'b0;
            prev_snap    <= '0;
            sample       <= '0;
            sample_valid <= 1'b0;
        end else begin
            base_q       <= base_sel;
            sample_valid <= report;
            if (restart || boundary) gate_cnt <= '0;
            else                     gate_cnt <= gate_cnt + GATE_W'(1);
            if (boundary && !restart) prev_snap <= cur_count;
            if (report)               sample    <= reading;
        end
    end

    link_state_fsm u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (report),
        .over     (over),
        .detached (disconnect)
    );
endmodule

// File: rtl/osc_cap_monitor_chk.sv
`timescale 1ns/1ps
module osc_cap_monitor_chk #(
    parameter int GATE_CYCLES = 125000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       base_sel,
    input logic [6:0] threshold,
    input logic [6:0] sample,
    input logic       sample_valid,
    input logic       disconnect
);
    localparam int            CW      = $clog2(GATE_CYCLES) + 2;
    localparam logic [CW-1:0] GAP     = CW'(GATE_CYCLES);
    localparam logic [CW-1:0] QUIET   = CW'(2 * GATE_CYCLES);

    logic [CW-1:0] gap_q;
    logic [CW-1:0] quiet_q;
    logic          seen_q;
    logic          base_d;
    logic          last_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            quiet_q <= '0;
            seen_q  <= 1'b0;
            base_d  <= 1'b0;
            last_hi <= 1'b0;
        end else begin
            base_d <= base_sel;
            if (sample_valid) gap_q <= CW'(1);
            else if (gap_q != '1) gap_q <= gap_q + CW'(1);
            if (base_sel != base_d) begin
                quiet_q <= QUIET;
                seen_q  <= 1'b0;
            end else begin
                if (quiet_q != '0) quiet_q <= quiet_q - CW'(1);
                if (sample_valid)  seen_q  <= 1'b1;
            end
            if (sample_valid) last_hi <= (sample > $past(threshold));
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sample_valid && !disconnect && sample == 7'd0));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    a_r3_window_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && seen_q && base_sel == base_d) |-> gap_q == GAP);

    a_r5_discard_after_base: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q != '0) |-> !sample_valid);

    a_r6_rise_two_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disconnect) |-> (sample > $past(threshold) && last_hi));

    a_r7_fall_two_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disconnect) |-> (sample <= $past(threshold) && !last_hi));

    a_r8_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(disconnect));

    a_r9_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample));
endmodule

bind osc_cap_monitor osc_cap_monitor_chk #(.GATE_CYCLES(GATE_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_sel     (base_sel),
    .threshold    (threshold),
    .sample       (sample),
    .sample_valid (sample_valid),
    .disconnect   (disconnect)
);

// File: tb/tb_osc_cap_monitor.sv
`timescale 1ns/1ps
module tb_osc_cap_monitor;
    localparam int G  = 500;
    localparam int CW = 12;
    localparam int WINDOW_NS = G * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_clk = 1'b0;
    logic          base_sel = 1'b0;
    logic [CW-1:0] baseline = 12'd40;
    logic [6:0]    threshold = 7'd127;
    logic [6:0]    sample;
    logic          sample_valid;
    logic          disconnect;

    int  checks = 0;
    int  errors = 0;
    int  osc_half = 10;
    int  settle = 1;
    bit  m_disc = 0;
    int  m_run = 0;
    bit  done = 0;
    int  seed_val;
    int  halves[7] = '{4, 5, 8, 10, 20, 25, 40};

    osc_cap_monitor #(.CNT_W(CW), .GATE_CYCLES(G)) dut (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .base_sel(base_sel),
        .baseline(baseline), .threshold(threshold), .sample(sample),
        .sample_valid(sample_valid), .disconnect(disconnect)
    );

    always #2 clk = ~clk;

    // Oscillator model: rising edges always fall on half-nanosecond points.
    initial begin
        #0.5;
        forever begin
            #(osc_half) osc_clk = 1'b1;
            #(osc_half) osc_clk = 1'b0;
        end
    end

    function automatic int exp_reading(int half, int base);
        int d;
        d = WINDOW_NS / (2 * half) - base;
        if (d < 0) return 0;
        if (d > 127) return 127;
        return d;
    endfunction

    task automatic check(bit ok, string req, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Wait for the next strobe, checking holds between strobes (R8, R9),
    // then the reading (R2) and the hysteresis model (R6, R7).
    task automatic wait_valid(output int cyc);
        logic [6:0] s0;
        logic       d0;
        int         bad;
        bit         hi;
        s0 = sample; d0 = disconnect; bad = 0; cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (!sample_valid && (sample != s0 || disconnect != d0)) bad++;
        end while (!sample_valid && cyc < 4 * G);
        check(bad == 0, "R8/R9 hold between strobes", bad, 0);
        if (settle > 0)
            check(sample == 7'(exp_reading(osc_half, int'(baseline))), "R2 reading",
                  int'(sample), exp_reading(osc_half, int'(baseline)));
        settle++;
        hi = (sample > threshold);
        if (!m_disc) begin
            m_run = hi ? m_run + 1 : 0;
            if (m_run == 2) begin m_disc = 1; m_run = 0; end
        end else begin
            m_run = hi ? 0 : m_run + 1;
            if (m_run == 2) begin m_disc = 0; m_run = 0; end
        end
        check(disconnect == m_disc, "R6/R7 disconnect flag", int'(disconnect), int'(m_disc));
    endtask

    task automatic set_thr_and_wait(int thr, int exp_flag, string req);
        int c;
        threshold = 7'(thr);
        wait_valid(c);
        check(c == G, "R3 strobe spacing", c, G);
        check(int'(disconnect) == exp_flag, req, int'(disconnect), exp_flag);
    endtask

    initial begin
        int c;
        seed_val = 32'h1234_5678;
        void'($urandom(seed_val));
        repeat (5) @(negedge clk);
        check(sample == 0 && !sample_valid && !disconnect, "R1 reset outputs",
              int'({sample, sample_valid, disconnect}), 0);
        rst_n = 1'b1;
        // R4: first window discarded
        wait_valid(c);
        check(c == 2 * G, "R4 first strobe delay", c, 2 * G);
        // reading 100-40 = 60; directed hysteresis sequences
        set_thr_and_wait(50, 0, "R6 one high window");
        set_thr_and_wait(70, 0, "R6 high then low");
        set_thr_and_wait(60, 0, "R6 equal is low");
        set_thr_and_wait(50, 0, "R6 first high");
        set_thr_and_wait(50, 1, "R6 second high sets");
        set_thr_and_wait(70, 1, "R7 one low window");
        set_thr_and_wait(50, 1, "R7 high restarts");
        set_thr_and_wait(70, 1, "R7 first low");
        set_thr_and_wait(60, 0, "R7 second low clears");
        // R2 clamp low
        baseline = 12'd120;
        set_thr_and_wait(0, 0, "R2 low clamp keeps low");
        check(sample == 0, "R2 clamp to zero", int'(sample), 0);
        // R2 clamp high: fast oscillator, zero baseline
        baseline = 12'd0; threshold = 7'd127; osc_half = 4; settle = 0;
        wait_valid(c);
        wait_valid(c);
        check(sample == 7'd127, "R2 clamp to 127", int'(sample), 127);
        // R5: base select flip discards a window
        base_sel = 1'b1; osc_half = 5; baseline = 12'd150; settle = 1;
        wait_valid(c);
        check(c == 2 * G + 1, "R5 strobe delay after base change", c, 2 * G + 1);
        base_sel = 1'b0; osc_half = 10; baseline = 12'd60;
        wait_valid(c);
        check(c == 2 * G + 1, "R5 strobe delay after second change", c, 2 * G + 1);
        // Random mix
        for (int i = 0; i < 40; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            threshold = 7'($urandom_range(0, 127));
            if (r < 3) baseline = CW'($urandom_range(0, 260));
            if (r == 9) begin
                osc_half = halves[$urandom_range(0, 6)];
                settle = 0;
            end
            wait_valid(c);
            check(c == G, "R3 strobe spacing random", c, G);
        end
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule